// File: doc/BRIEF.md
# Strided Block-Copy DMA Channel with Coalesced Completion

This block is one channel of a memory-to-memory copy engine that sits on a single-master word bus with a valid/ready handshake. A pulse on the trigger input, normally wired from a peripheral's interrupt line, starts one block. A block is a rectangle of `cols` elements by `rows` rows. Each element is one 32-bit word. It is read from the source address and then written unchanged to the destination address.

The source and destination walkers advance independently. After every element a walker adds its signed element step. After the last element of a row it instead moves to its row origin plus a signed row step. Two programmed steps per side can therefore express strided gathers, reversals and a full matrix transpose in a single block. The walkers keep their position between blocks, so consecutive triggers fill a buffer end to end.

The CPU writes the setup registers once. It is interrupted only after a programmed number of blocks has finished. The interrupt is a sticky flag that the CPU clears by writing a one.

Top module: `dma_ofs_channel`

## Requirements
- R1: When the channel is idle and a trigger pulse is seen, the first source read request appears on the bus in the second cycle after the trigger cycle.
- R2: Each element is a read at the source address followed by a write of the same 32-bit word to the destination address. No new read is requested until the write has been accepted.
- R3: Within a row, after each element the source and destination addresses each add their own signed element step (registers 2 and 3, two's complement, wrapping modulo the address width).
- R4: After the last element of a row, each address becomes that row's origin plus its signed row step (registers 4 and 5). Register 6 holds cols−1 in bits [CNT_W−1:0] and rows−1 in bits [16+CNT_W−1:16].
- R5: Writing register 0 or 1 loads the source or destination address and its row origin. Otherwise the addresses continue from where the previous block left them.
- R6: Triggers that arrive while a block is running are counted, not dropped. Each of them starts one further block afterwards.
- R7: `irq` rises only when the number of finished blocks reaches the coalescing count in register 7 bits [CNT_W−1:0], which is encoded as count−1. The block counter then restarts from zero.
- R8: `irq` stays set until register 7 is written with bit 31 set. A write to register 7 with bit 31 clear leaves `irq` unchanged.
- R9: While a bus request is waiting for `mem_ready`, the request, its direction, its address and its write data stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Setup register write strobe |
| cfg_sel | input | 3 | Setup register index (0..7) |
| cfg_wdata | input | 32 | Setup register write data |
| trig | input | 1 | Block start request, one pulse per block |
| mem_req | output | 1 | Bus request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Bus accepts the request this cycle; read data valid |
| mem_rdata | input | 32 | Read data |
| irq | output | 1 | Sticky completion interrupt |

## Verification
The bench builds the channel with AW=16 and CNT_W=8, against a 256-word memory model whose ready line stalls every third cycle. This small configuration makes it practical to sweep every block shape from 1×1 to 4×4 as a transpose, comparing each destination word and the guard word beyond the block. Separate runs cover a reversed-order strided gather with a negative step, chained blocks that continue across triggers, triggers queued while a block is running, and the coalesced interrupt with its write-one clear.

// File: rtl/dma_ofs_pkg.sv
package dma_ofs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } seq_st_e;

  typedef struct packed {
    logic [31:0] ptr;
    logic [31:0] origin;
  } walk_t;

  // Next position of an address walker after one element.
  function automatic walk_t walk_next(input logic [31:0] ptr,
                                     input logic [31:0] origin,
                                     input logic [31:0] elem_step,
                                     input logic [31:0] row_step,
                                     input logic        row_end);
    walk_t w;
    if (row_end) begin
      w.origin = origin + row_step;
      w.ptr    = origin + row_step;
    end else begin
      w.origin = origin;
      w.ptr    = ptr + elem_step;
    end
    return w;
  endfunction

endpackage

// File: rtl/dma_ofs_cfg.sv
module dma_ofs_cfg #(
  parameter int AW    = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_sel,
  input  logic [31:0]      cfg_wdata,
  output logic             ld_src,
  output logic             ld_dst,
  output logic [AW-1:0]    wr_val,
  output logic [AW-1:0]    src_estep,
  output logic [AW-1:0]    dst_estep,
  output logic [AW-1:0]    src_rstep,
  output logic [AW-1:0]    dst_rstep,
  output logic [CNT_W-1:0] cols_m1,
  output logic [CNT_W-1:0] rows_m1,
  output logic [CNT_W-1:0] blk_m1,
  output logic             clr_done
);
  localparam int RowLsb = 16;

  assign wr_val   = cfg_wdata[AW-1:0];
  assign ld_src   = cfg_we && (cfg_sel == 3'd0);
  assign ld_dst   = cfg_we && (cfg_sel == 3'd1);
  assign clr_done = cfg_we && (cfg_sel == 3'd7) && cfg_wdata[31];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_estep <= '0;
      dst_estep <= '0;
      src_rstep <= '0;
      dst_rstep <= '0;
      cols_m1   <= '0;
      rows_m1   <= '0;
      blk_m1    <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        3'd2: src_estep <= cfg_wdata[AW-1:0];
        3'd3: dst_estep <= cfg_wdata[AW-1:0];
        3'd4: src_rstep <= cfg_wdata[AW-1:0];
        3'd5: dst_rstep <= cfg_wdata[AW-1:0];
        3'd6: begin
          cols_m1 <= cfg_wdata[CNT_W-1:0];
          rows_m1 <= cfg_wdata[RowLsb +: CNT_W];
        end
        3'd7: blk_m1 <= cfg_wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/dma_ofs_agen.sv
module dma_ofs_agen
  import dma_ofs_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic          adv,
  input  logic          row_end,
  input  logic [AW-1:0] elem_step,
  input  logic [AW-1:0] row_step,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] ptr_q;
  logic [AW-1:0] origin_q;
  walk_t         nx;

  always_comb nx = walk_next(32'(ptr_q), 32'(origin_q),
                             32'(elem_step), 32'(row_step), row_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      origin_q <= '0;
    end else if (load) begin
      ptr_q    <= base;
      origin_q <= base;
    end else if (adv) begin
      ptr_q    <= nx.ptr[AW-1:0];
      origin_q <= nx.origin[AW-1:0];
    end
  end

  assign addr = ptr_q;

  a_r3_elem_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !row_end && !load) |=> (addr == AW'($past(addr) + $past(elem_step))));

  a_r4_row_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && row_end && !load) |=> (addr == AW'($past(origin_q) + $past(row_step))));

  a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (addr == $past(base)));

endmodule

// File: rtl/dma_ofs_seq.sv
module dma_ofs_seq
  import dma_ofs_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic [CNT_W-1:0] cols_m1,
  input  logic [CNT_W-1:0] rows_m1,
  input  logic [CNT_W-1:0] blk_m1,
  input  logic             clr_done,
  input  logic             mem_ready,
  input  logic [31:0]      mem_rdata,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      wdata,
  output logic             adv,
  output logic             row_end,
  output logic             done
);
  localparam logic [PW-1:0] PendMax = {PW{1'b1}};

  seq_st_e          st_q;
  logic [PW-1:0]    pend_q;
  logic [CNT_W-1:0] col_q, row_q, blk_q;

  // named internal events
  logic start, rd_done, elem_done, last_row, blk_end, trig_take;

  assign start     = (st_q == ST_IDLE) && (pend_q != '0);
  assign rd_done   = (st_q == ST_RD) && mem_ready;
  assign elem_done = (st_q == ST_WR) && mem_ready;
  assign row_end   = (col_q == cols_m1);
  assign last_row  = (row_q == rows_m1);
  assign blk_end   = elem_done && row_end && last_row;
  assign trig_take = trig && (pend_q != PendMax);
  assign adv       = elem_done;

  assign mem_req = (st_q == ST_RD) || (st_q == ST_WR);
  assign mem_we  = (st_q == ST_WR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pend_q <= '0;
      col_q  <= '0;
      row_q  <= '0;
      blk_q  <= '0;
      wdata  <= '0;
      done   <= 1'b0;
    end else begin
      pend_q <= pend_q + PW'(trig_take) - PW'(start);
      case (st_q)
        ST_IDLE: if (start) begin
          st_q  <= ST_RD;
          col_q <= '0;
          row_q <= '0;
        end
        ST_RD: if (rd_done) begin
          wdata <= mem_rdata;
          st_q  <= ST_WR;
        end
        ST_WR: if (elem_done) begin
          st_q <= blk_end ? ST_IDLE : ST_RD;
          if (row_end) begin
            col_q <= '0;
            row_q <= row_q + 1'b1;
          end else begin
            col_q <= col_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
      if (blk_end) begin
        blk_q <= (blk_q == blk_m1) ? '0 : blk_q + 1'b1;
      end
      if (blk_end && (blk_q == blk_m1)) done <= 1'b1;
      else if (clr_done)                done <= 1'b0;
    end
  end

  a_r2_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> (mem_req && mem_we));

  a_r2_write_data: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> (wdata == $past(mem_rdata)));

  a_r9_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) && $stable(wdata)));

  a_r6_keep_trig: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && st_q != ST_IDLE) |=> (pend_q != '0));

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr_done) |=> done);

  a_r7_rise_on_block: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(blk_end));

endmodule

// File: rtl/dma_ofs_channel.sv
module dma_ofs_channel #(
  parameter int AW    = 16,
  parameter int CNT_W = 8,
  parameter int PW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  input  logic          trig,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ready,
  input  logic [31:0]   mem_rdata,
  output logic          irq
);
  logic             ld_src, ld_dst, clr_done, adv, row_end;
  logic [AW-1:0]    wr_val, src_estep, dst_estep, src_rstep, dst_rstep;
  logic [AW-1:0]    src_addr, dst_addr;
  logic [CNT_W-1:0] cols_m1, rows_m1, blk_m1;

  dma_ofs_cfg #(.AW(AW), .CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .ld_src(ld_src), .ld_dst(ld_dst), .wr_val(wr_val),
    .src_estep(src_estep), .dst_estep(dst_estep), .src_rstep(src_rstep),
    .dst_rstep(dst_rstep), .cols_m1(cols_m1), .rows_m1(rows_m1),
    .blk_m1(blk_m1), .clr_done(clr_done)
  );

  dma_ofs_agen #(.AW(AW)) u_src (
    .clk(clk), .rst_n(rst_n), .load(ld_src), .base(wr_val), .adv(adv),
    .row_end(row_end), .elem_step(src_estep), .row_step(src_rstep),
    .addr(src_addr)
  );

  dma_ofs_agen #(.AW(AW)) u_dst (
    .clk(clk), .rst_n(rst_n), .load(ld_dst), .base(wr_val), .adv(adv),
    .row_end(row_end), .elem_step(dst_estep), .row_step(dst_rstep),
    .addr(dst_addr)
  );

  dma_ofs_seq #(.CNT_W(CNT_W), .PW(PW)) u_seq (
    .clk(clk), .rst_n(rst_n), .trig(trig), .cols_m1(cols_m1),
    .rows_m1(rows_m1), .blk_m1(blk_m1), .clr_done(clr_done),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .wdata(mem_wdata), .adv(adv), .row_end(row_end),
    .done(irq)
  );

  assign mem_addr = mem_we ? dst_addr : src_addr;

  a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready && !cfg_we) |=> $stable(mem_addr));

endmodule

// File: tb/test_dma_ofs_channel.sv
module test_dma_ofs_channel;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_sel = '0;
  logic [31:0]   cfg_wdata = '0;
  logic          trig = 1'b0;
  logic          mem_req, mem_we, irq;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata, mem_rdata;
  logic          mem_ready = 1'b0;

  logic [31:0] mem [0:255];
  int vectors = 0;
  int errors  = 0;
  int cyc     = 0;
  int stall   = 0;
  logic          p_req = 1'b0, p_rdy = 1'b0, p_we = 1'b0;
  logic [AW-1:0] p_addr = '0;
  logic [31:0]   p_wd = '0;

  dma_ofs_channel #(.AW(AW)) i_dma_ofs_channel (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .trig(trig), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .irq(irq)
  );

  always #2 clk = ~clk;

  assign mem_rdata = mem[mem_addr[9:2]];
  always @(posedge clk)
    if (mem_req && mem_ready && mem_we) mem[mem_addr[9:2]] <= mem_wdata;

  // ready pattern and R9 handshake monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (p_req && !p_rdy) begin
        vectors++;
        if (!mem_req || mem_addr != p_addr || mem_we != p_we || (p_we && mem_wdata != p_wd)) begin
          errors++;
          $display("FAIL R9 held request changed: addr %h exp %h", mem_addr, p_addr);
        end
      end
    end
    p_req  = mem_req;
    p_addr = mem_addr;
    p_we   = mem_we;
    p_wd   = mem_wdata;
    stall  = stall + 1;
    mem_ready = (stall % 3) != 2;
    p_rdy  = mem_ready;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 3000 && !irq; i++) @(negedge clk);
  endtask

  task automatic setup(input int sb, input int db, input int se, input int de,
                       input int sr, input int dr, input int cols, input int rows,
                       input int blks);
    wr(0, 32'(sb)); wr(1, 32'(db));
    wr(2, 32'(se)); wr(3, 32'(de)); wr(4, 32'(sr)); wr(5, 32'(dr));
    wr(6, (32'(rows - 1) << 16) | 32'(cols - 1));
    wr(7, 32'h8000_0000 | 32'(blks - 1));
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = (i < 128) ? 32'hA000_0000 + 32'(i) : 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(irq == 1'b0, "R7 reset irq", 32'(irq), 0);
    chk(mem_req == 1'b0, "R1 reset idle bus", 32'(mem_req), 0);

    // R1 R3 R4: transpose sweep over every shape up to 4x4
    for (int r = 1; r <= 4; r++) begin
      for (int c = 1; c <= 4; c++) begin
        for (int k = 128; k < 256; k++) mem[k] = 32'h0;
        setup(0, 'h200, 4, r * 4, c * 4, 4, c, r, 1);
        pulse();
        wait_irq();
        chk(irq == 1'b1, "R7 irq after transpose", 32'(irq), 1);
        for (int y = 0; y < r; y++)
          for (int x = 0; x < c; x++)
            chk(mem[128 + x * r + y] == 32'hA000_0000 + 32'(y * c + x),
                "R4 transpose word", mem[128 + x * r + y], 32'hA000_0000 + 32'(y * c + x));
        chk(mem[128 + r * c] == 32'h0, "R2 guard word untouched", mem[128 + r * c], 0);
      end
    end

    // R3 R1: strided gather stored in reverse with a negative step
    for (int k = 128; k < 256; k++) mem[k] = 32'h0;
    setup('h10, 'h210, 12, -4, 0, 0, 5, 1, 1);
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    @(negedge clk);
    chk(mem_req == 1'b1 && mem_we == 1'b0 && mem_addr == 16'h0010,
        "R1 first read two cycles after trigger", 32'(mem_addr), 32'h10);
    wait_irq();
    for (int k = 0; k < 5; k++)
      chk(mem[132 - k] == 32'hA000_0000 + 32'(4 + 3 * k), "R3 gather reverse",
          mem[132 - k], 32'hA000_0000 + 32'(4 + 3 * k));
    chk(mem[127] == 32'hA000_007F, "R3 below reverse untouched", mem[127], 32'hA000_007F);

    // R5 R7: chained blocks, coalesced over three
    for (int k = 128; k < 256; k++) mem[k] = 32'h0;
    setup('h40, 'h280, 4, 4, 8, 8, 2, 1, 3);
    pulse(); pulse();
    repeat (300) @(negedge clk);
    chk(irq == 1'b0, "R7 no irq after two of three blocks", 32'(irq), 0);
    pulse();
    wait_irq();
    chk(irq == 1'b1, "R7 irq after third block", 32'(irq), 1);
    for (int k = 0; k < 6; k++)
      chk(mem[160 + k] == 32'hA000_0010 + 32'(k), "R5 blocks continue",
          mem[160 + k], 32'hA000_0010 + 32'(k));

    // R8: write without bit 31 ignored, with bit 31 clears
    wr(7, 32'h0000_0002);
    chk(irq == 1'b1, "R8 clear bit absent keeps irq", 32'(irq), 1);
    wr(7, 32'h8000_0002);
    chk(irq == 1'b0, "R8 write one clears irq", 32'(irq), 0);

    // R6: three back-to-back triggers, two arrive while busy
    @(negedge clk); trig = 1'b1;
    repeat (3) @(negedge clk);
    trig = 1'b0;
    wait_irq();
    chk(irq == 1'b1, "R6 all queued blocks ran", 32'(irq), 1);
    for (int k = 0; k < 6; k++)
      chk(mem[166 + k] == 32'hA000_0016 + 32'(k), "R6 queued block data",
          mem[166 + k], 32'hA000_0016 + 32'(k));
    chk(mem[172] == 32'h0, "R6 no extra block", mem[172], 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule